// File: doc/BRIEF.md
# Serial/Parallel FIFO Input Stage

This block is the entry stage of a FIFO. It collects one word at a time, either as a whole nibble captured while a load strobe is high or as a stream of single bits clocked in on the falling edges of a serial clock. When a complete word is held, an active-low full flag drops. The word is then handed to a downstream stack on a one-cycle push strobe. The push happens when a transfer request is low and the stack reports that its top slot is free. After the push, the stage clears itself and is ready for the next word.

Completion of a serial word is found by a marker bit. Clearing the stage seeds a one into the most significant data stage. Each serial shift moves that one down the chain by one place. When the one lands in a fifth stage, four bits have arrived. A guard flop ensures that a held word is pushed only once, however long the request stays low. A master latch, loaded during reset, decides whether the stage clears itself at once after a push or waits for its serial-enable input to fall. With this latch, chained slices clear in order along a row.

All control inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are found on the synchronized copies. As a result, every input takes effect on the third rising clock edge after it changes.

Top module: `fifo_in_stage`

## Requirements
- R1: While `rstN` is low the stage clears: `fullN` is 1 and `pushStrobe` is 0. The master latch takes the inverse of the synchronized `serialEnN`, so it is set if `serialEnN` is low during reset.
- R2: A high `loadStrobe` captures `parData` and drops `fullN` within three clock edges. A later push carries that value, with `parData[3]` in the most significant position.
- R3: While `serialEnN` is low, each falling edge of `serialClk` takes in one `serialBit`. `fullN` stays high until the fourth bit and drops after it. The first bit received lands in `pushData[0]` and the fourth in `pushData[3]`.
- R4: Falling edges of `serialClk` while `serialEnN` is high change nothing.
- R5: Once a word is complete, further serial clock edges leave it unchanged until the stage clears.
- R6: A push happens when `xferReqN` is low, the word is complete, the word has not yet been pushed, and `stackTopEmpty` is high. The push is a `pushStrobe` pulse one cycle long that carries the word on `pushData`.
- R7: While `stackTopEmpty` is low, no push occurs and `fullN` stays low.
- R8: A held word is pushed only once. While `loadStrobe` stays high after a push, the stage neither reloads nor clears, and `fullN` stays low.
- R9: With the master latch set, the stage clears on the first cycle after the push in which `loadStrobe` is low, and `fullN` returns high.
- R10: With the master latch clear, the stage stays full after a push until `serialEnN` goes low, and then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadStrobe | input | 1 | Parallel capture request, high active, asynchronous |
| parData | input | WORD_W (4) | Parallel word |
| serialClk | input | 1 | Serial bit clock; falling edge shifts, asynchronous |
| serialBit | input | 1 | Serial data |
| serialEnN | input | 1 | Serial enable, low active; also the row enable for clearing |
| xferReqN | input | 1 | Transfer-to-stack request, low active |
| stackTopEmpty | input | 1 | Stack top slot free, synchronous to clk |
| pushStrobe | output | 1 | One-cycle push into the stack |
| pushData | output | WORD_W (4) | Word being pushed |
| fullN | output | 1 | Low while a complete word is held |

## Verification
Parallel words with different bit patterns show whether the capture keeps the bits in order. A serial train of 1,0,1,1 tells a correct shift order apart from a reversed one. Serial edges given while disabled, and extra edges given after completion, would each leave a different wrong value in the pushed word if they were taken in. Holding the load strobe high with the request low would expose a double push. A run with the stack top blocked, and a reset taken with the enable high, separates the path that clears at once from the one that waits.

// File: rtl/fifo_in_pkg.sv
package fifo_in_pkg;
  typedef struct packed {
    logic init;
    logic load;
    logic shift;
    logic push;
  } stageCtl_t;
endpackage

// File: rtl/fifo_in_sync.sv
module fifo_in_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chainQ [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : gStage
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk) chainQ[gi] <= din;
      end else begin : gRest
        always_ff @(posedge clk) chainQ[gi] <= chainQ[gi-1];
      end
    end
  endgenerate

  assign dout = chainQ[STAGES-1];
endmodule

// File: rtl/fifo_in_ctrl.sv
module fifo_in_ctrl
  import fifo_in_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ldS,
  input  logic      sclkFall,
  input  logic      enS,
  input  logic      xferS,
  input  logic      stackTopEmpty,
  input  logic      marker,
  output stageCtl_t ctl,
  output logic      guard,
  output logic      masterLatch
);
  always_comb begin
    ctl.push  = !xferS && marker && !guard && stackTopEmpty;
    ctl.init  = guard && !ldS && (masterLatch || !enS);
    ctl.load  = ldS && !guard && !ctl.push;
    ctl.shift = sclkFall && !enS && !marker && !ldS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      guard       <= 1'b0;
      masterLatch <= !enS;
    end else if (ctl.push) begin
      guard <= 1'b1;
    end else if (ctl.init) begin
      guard <= 1'b0;
    end
  end

  // R8: a held load keeps the guard set
  assert_load_holds_guard_R8: assert property (@(posedge clk) disable iff (!rstN)
    (guard && ldS) |=> guard);
endmodule

// File: rtl/fifo_in_datapath.sv
module fifo_in_datapath
  import fifo_in_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         ctl,
  input  logic [WORD_W-1:0] dataS,
  input  logic              bitS,
  output logic              marker,
  output logic              pushStrobe,
  output logic [WORD_W-1:0] pushData
);
  localparam int CHAIN_W = WORD_W + 1;
  localparam logic [CHAIN_W-1:0] SEED = {1'b1, {WORD_W{1'b0}}};

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.init) chain <= SEED;
    else if (ctl.load)     chain <= {dataS, 1'b1};
    else if (ctl.shift)    chain <= {bitS, chain[CHAIN_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pushStrobe <= 1'b0;
      pushData   <= '0;
    end else begin
      pushStrobe <= ctl.push;
      if (ctl.push) pushData <= chain[CHAIN_W-1:1];
    end
  end

  assign marker = chain[0];

  // R5: a complete word is frozen unless reloaded or cleared
  assert_full_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (marker && !ctl.init && !ctl.load) |=> $stable(chain));
endmodule

// File: rtl/fifo_in_stage.sv
module fifo_in_stage
  import fifo_in_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStrobe,
  input  logic [WORD_W-1:0] parData,
  input  logic              serialClk,
  input  logic              serialBit,
  input  logic              serialEnN,
  input  logic              xferReqN,
  input  logic              stackTopEmpty,
  output logic              pushStrobe,
  output logic [WORD_W-1:0] pushData,
  output logic              fullN
);
  localparam int SYNC_W = WORD_W + 5;

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic [WORD_W-1:0] dataS;
  logic ldS, sclkS, bitS, enS, xferS, sclkPrev, sclkFall;
  logic marker, guard, masterLatch;
  stageCtl_t ctl;

  assign rawIn = {parData, loadStrobe, serialClk, serialBit, serialEnN, xferReqN};
  assign {dataS, ldS, sclkS, bitS, enS, xferS} = syncOut;

  fifo_in_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .din(rawIn), .dout(syncOut));

  always_ff @(posedge clk) sclkPrev <= sclkS;
  assign sclkFall = sclkPrev && !sclkS;

  fifo_in_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ldS(ldS), .sclkFall(sclkFall), .enS(enS),
    .xferS(xferS), .stackTopEmpty(stackTopEmpty), .marker(marker),
    .ctl(ctl), .guard(guard), .masterLatch(masterLatch));

  fifo_in_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataS(dataS), .bitS(bitS),
    .marker(marker), .pushStrobe(pushStrobe), .pushData(pushData));

  assign fullN = !marker;

  // R7: a push only follows a cycle with a free stack top and a full word
  assert_push_needs_room_R7: assert property (@(posedge clk) disable iff (!rstN)
    pushStrobe |-> ($past(stackTopEmpty) && !$past(fullN)));
  // R8: never two pushes back to back
  assert_one_push_R8: assert property (@(posedge clk) disable iff (!rstN)
    pushStrobe |=> !pushStrobe);
  // R9: the stage only empties after a recorded push
  assert_rearm_after_push_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(fullN)) |-> $past(guard));
endmodule

// File: tb/sim_fifo_in_stage.sv
`timescale 1ns/1ps
module sim_fifo_in_stage;
  logic clk = 0, rstN = 0;
  logic loadStrobe = 0, serialClk = 0, serialBit = 0, serialEnN = 0;
  logic xferReqN = 1, stackTopEmpty = 1;
  logic [3:0] parData = 0;
  logic pushStrobe, fullN;
  logic [3:0] pushData;

  always #2.5 clk = !clk;

  fifo_in_stage u0 (.clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .parData(parData),
    .serialClk(serialClk), .serialBit(serialBit), .serialEnN(serialEnN),
    .xferReqN(xferReqN), .stackTopEmpty(stackTopEmpty), .pushStrobe(pushStrobe),
    .pushData(pushData), .fullN(fullN));

  int checks = 0, fails = 0;
  bit done = 0;
  int got[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: inputs seen two edges late, bit count instead of a chain
  int hLd[$], hClk[$], hBit[$], hEn[$], hX[$], hData[$];
  int mWord = 0, mCnt = 0, mFull = 0, mGuard = 0, mMaster = 0, mPush = 0, mPushData = 0;
  bit mReady = 0;
  always @(posedge clk) begin
    int n, ld, en, xr, bt, dd, fall;
    ld = 0; en = 1; xr = 1; bt = 0; dd = 0; fall = 0;
    n = hLd.size();
    if (n >= 3) begin
      ld = hLd[n-2]; en = hEn[n-2]; xr = hX[n-2]; bt = hBit[n-2]; dd = hData[n-2];
      fall = hClk[n-3] && !hClk[n-2];
      mReady = 1;
    end
    mPush = 0;
    if (!rstN) begin
      mWord = 0; mCnt = 0; mFull = 0; mGuard = 0; mMaster = !en;
    end else if (!xr && mFull && !mGuard && stackTopEmpty) begin
      mPush = 1; mPushData = mWord; mGuard = 1;
    end else if (mGuard && !ld && (mMaster || !en)) begin
      mWord = 0; mCnt = 0; mFull = 0; mGuard = 0;
    end else if (ld && !mGuard) begin
      mWord = dd; mFull = 1;
    end else if (fall && !en && !mFull) begin
      mWord = mWord | (bt << mCnt); mCnt++;
      if (mCnt == 4) mFull = 1;
    end
    hLd.push_back(loadStrobe); hClk.push_back(serialClk); hBit.push_back(serialBit);
    hEn.push_back(serialEnN); hX.push_back(xferReqN); hData.push_back(parData);
    if (hLd.size() > 4) begin
      void'(hLd.pop_front()); void'(hClk.pop_front()); void'(hBit.pop_front());
      void'(hEn.pop_front()); void'(hX.pop_front()); void'(hData.pop_front());
    end
  end

  always @(negedge clk) if (mReady && !done) begin
    chk("R3 fullN vs model", fullN, !mFull);
    chk("R6 pushStrobe vs model", pushStrobe, mPush);
    if (mPush) chk("R6 pushData vs model", pushData, mPushData);
  end

  always @(posedge clk) begin
    #1;
    if (pushStrobe) got.push_back(pushData);
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    serialBit = b; serialClk = 1; cyc(3);
    serialClk = 0; cyc(3);
  endtask

  task automatic expectPush(string tag, int val);
    chk(tag, got.size(), 1);
    if (got.size() >= 1) chk(tag, got[0], val);
    got.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(6); rstN = 1; cyc(2);
    // R1 reset state
    chk("R1 fullN after reset", fullN, 1);
    chk("R1 no push after reset", pushStrobe, 0);

    // R2 parallel load then R9 immediate rearm
    parData = 4'hA; loadStrobe = 1; cyc(4);
    chk("R2 fullN after load", fullN, 0);
    loadStrobe = 0; cyc(4);
    chk("R2 held without request", fullN, 0);
    xferReqN = 0; cyc(6);
    expectPush("R2 pushed word A", 4'hA);
    chk("R9 fullN after push", fullN, 1);
    xferReqN = 1; cyc(2);

    // R3 serial order, R5 extra edges ignored
    sendBit(1); sendBit(0); sendBit(1);
    chk("R3 not full after three bits", fullN, 1);
    sendBit(1);
    chk("R3 full after four bits", fullN, 0);
    sendBit(0); sendBit(0);
    chk("R5 still full", fullN, 0);
    xferReqN = 0; cyc(6);
    expectPush("R3 R5 serial word", 4'hD);
    xferReqN = 1; cyc(2);

    // R4 disabled serial edges
    serialEnN = 1; cyc(3);
    sendBit(1); sendBit(1);
    chk("R4 no fill while disabled", fullN, 1);
    serialEnN = 0; cyc(3);
    sendBit(0); sendBit(0); sendBit(0); sendBit(0);
    xferReqN = 0; cyc(6);
    expectPush("R4 disabled bits ignored", 0);
    xferReqN = 1; cyc(2);

    // R7 stack top not free
    stackTopEmpty = 0; parData = 4'h5; loadStrobe = 1; cyc(4);
    loadStrobe = 0; xferReqN = 0; cyc(8);
    chk("R7 no push while blocked", got.size(), 0);
    chk("R7 still full while blocked", fullN, 0);
    stackTopEmpty = 1; cyc(4);
    expectPush("R7 push after unblock", 4'h5);

    // R8 one-shot with load held high
    parData = 4'h9; loadStrobe = 1; cyc(12);
    expectPush("R8 single push", 4'h9);
    chk("R8 full while load held", fullN, 0);
    loadStrobe = 0; cyc(4);
    chk("R9 rearm after load low", fullN, 1);
    chk("R8 no second push", got.size(), 0);
    xferReqN = 1; cyc(2);

    // R10 slave: reset with enable high
    serialEnN = 1; rstN = 0; cyc(5); rstN = 1; cyc(3);
    parData = 4'h6; loadStrobe = 1; cyc(3); loadStrobe = 0; cyc(3);
    xferReqN = 0; cyc(8);
    expectPush("R10 slave push", 4'h6);
    chk("R10 slave waits", fullN, 0);
    serialEnN = 0; cyc(5);
    chk("R10 slave clears on enable", fullN, 1);
    chk("R10 no extra push", got.size(), 0);
    xferReqN = 1; cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule